// File: doc/BRIEF.md
# Core-Local Interrupt Controller with Level/Priority Arbitration

This block collects interrupt lines for one machine-mode hart and presents a single request to it. Every source has its own four-byte record of pending, enable, attribute and control bytes. The attribute byte selects how the source is sampled (level, rising edge or falling edge) and whether it is taken vectored. The control byte holds a level and a priority. A programmable count in the global configuration byte sets where the level field ends and the priority field begins.

Every cycle the controller searches the pending and enabled sources for the highest-ranked one. It registers that source's ID, its effective level and its vectored flag. It raises the request only when that level is strictly above the threshold byte. A byte-wide register bus gives software access to the configuration, the threshold, a read-only information word and the per-source records. Software can also set a pending bit by writing it, which gives a software-triggered interrupt.

Top module: `hart_intc`

## Requirements
- R1: Source i has a record at byte address 0x100 + 4*i. Offset 0 is pending (bit 0), offset 1 is enable (bit 0), offset 2 is attribute and offset 3 is control. In the attribute byte, bit 0 is the vectored flag and bits 2:1 select the trigger: 0 level, 1 rising, 2 falling, 3 treated as level. Bits that are not implemented read as zero.
- R2: Only the upper CTL_BITS bits of each control byte are stored, and the lower bits always read as one. With the default of 4, a control byte reads 0x0F after reset and 0xAF after a write of 0xA5.
- R3: The configuration byte at 0x000 holds the level-bit count in bits 4:1. All other bits read zero, and the byte resets to zero.
- R4: Addresses 0x004 to 0x007 hold a read-only information word, little-endian. Bits 12:0 give NUM_SRC, bits 20:13 give VERSION and bits 24:21 give CTL_BITS. With the defaults it reads 08 20 80 00, and writes to it are ignored.
- R5: The threshold byte at 0x008 is fully writable and resets to zero.
- R6: An edge-triggered source becomes pending on its selected edge of the synchronized input, or on a write of 1. It leaves pending only when a 0 is written, and an edge in the same cycle as that write wins.
- R7: In a level-triggered source, pending follows the synchronized input, and writes to the pending byte have no effect.
- R8: The effective level count is the minimum of the level-bit count and CTL_BITS. The reported level keeps that many top bits of the control byte and sets every lower bit to one.
- R9: Arbitration considers only sources that are both pending and enabled. The highest level wins. A level tie goes to the higher priority, and a full tie goes to the higher source ID.
- R10: irq_req is high only when the winner's level is strictly greater than the threshold. With no pending and enabled source it is low.
- R11: irq_id, irq_level and irq_vec are registered and describe the winner even when it is below the threshold. All three are 0 when no source is a candidate.
- R12: Reset clears every per-source register and irq_req. Read data appears on bus_rdata one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| src_in | input | NUM_SRC | Asynchronous interrupt source lines |
| irq_req | output | 1 | Interrupt request to the hart |
| irq_id | output | IDX_W | Winning source ID |
| irq_level | output | 8 | Winning source's effective level |
| irq_vec | output | 1 | Winning source is vectored |

## Verification
Some properties are checked by assertions on every cycle. A request always names a source that was pending and enabled, with a level above the previous threshold and a vectored flag that matches that source. Edge-mode pending bits never drop unless software writes a 0, and level-mode pending bits track the synchronized input. Other behaviour can only be shown by the bench's scenarios. These cover the ranking order (level before priority before ID), the effect of the level-bit count on the reported level, the register read-back with its one-filled low control bits, and the fact that writes to the information word and to level-mode pending bits are ignored.

// File: rtl/hart_intc_pkg.sv
`timescale 1ns/1ps
package hart_intc_pkg;
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_RSVD  = 2'd3
    } trig_e;

    localparam int REC_BYTES = 4;
    localparam int REC_BASE  = 'h100;
    localparam int CFG_ADDR  = 'h000;
    localparam int INFO_ADDR = 'h004;
    localparam int THR_ADDR  = 'h008;
endpackage

// File: rtl/hart_intc_sync.sv
`timescale 1ns/1ps
module hart_intc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/hart_intc_src.sv
`timescale 1ns/1ps
module hart_intc_src
    import hart_intc_pkg::*;
#(
    parameter int CTL_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic [3:0]          wr_strb,
    input  logic [7:0]          wdata,
    output logic                pend,
    output logic                en,
    output logic                vec,
    output logic [1:0]          trig,
    output logic [CTL_BITS-1:0] ctl_hi
);
    typedef struct packed {
        logic                pend;
        logic                en;
        logic                vec;
        logic [1:0]          trig;
        logic [CTL_BITS-1:0] ctl;
        logic                prev;
    } rec_t;

    rec_t st_q, st_d;
    logic edge_mode, edge_hit;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        edge_mode = (st_q.trig == TRIG_RISE) || (st_q.trig == TRIG_FALL);
        case (st_q.trig)
            TRIG_RISE: edge_hit = sync_in & ~st_q.prev;
            TRIG_FALL: edge_hit = ~sync_in & st_q.prev;
            default:   edge_hit = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = sync_in;
        if (wr_strb[1]) st_d.en = wdata[0];
        if (wr_strb[2]) begin
            st_d.vec  = wdata[0];
            st_d.trig = wdata[2:1];
        end
        if (wr_strb[3]) st_d.ctl = wdata[7 -: CTL_BITS];

        if (edge_mode) begin
            if (wr_strb[0]) st_d.pend = wdata[0];
            if (edge_hit)   st_d.pend = 1'b1;
        end else begin
            st_d.pend = sync_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend   = st_q.pend;
    assign en     = st_q.en;
    assign vec    = st_q.vec;
    assign trig   = st_q.trig;
    assign ctl_hi = st_q.ctl;
endmodule

// File: rtl/hart_intc_arb.sv
`timescale 1ns/1ps
module hart_intc_arb #(
    parameter int NUM_SRC  = 8,
    parameter int CTL_BITS = 4,
    parameter int IDX_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      pend,
    input  logic [NUM_SRC-1:0]      en,
    input  logic [NUM_SRC-1:0]      vec,
    input  logic [NUM_SRC-1:0][7:0] ctl_byte,
    input  logic [3:0]              nl_eff,
    input  logic [7:0]              thr,
    output logic                    irq_req,
    output logic [IDX_W-1:0]        irq_id,
    output logic [7:0]              irq_level,
    output logic                    irq_vec
);
    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] id;
        logic [7:0]       level;
        logic             vec;
    } out_t;

    out_t st_q, st_d;
    logic             found;
    logic [7:0]       best_key;
    logic [IDX_W-1:0] best_id;
    logic             best_vec;
    logic [7:0]       best_lvl;

    always_comb begin
        found    = 1'b0;
        best_key = '0;
        best_id  = '0;
        best_vec = 1'b0;
        // ascending scan with >= lets the higher ID win a full tie
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && en[i] && (!found || ctl_byte[i] >= best_key)) begin
                found    = 1'b1;
                best_key = ctl_byte[i];
                best_id  = IDX_W'(i);
                best_vec = vec[i];
            end
        end
        best_lvl = best_key | (8'hFF >> nl_eff);

        st_d.req   = found && (best_lvl > thr);
        st_d.id    = found ? best_id : '0;
        st_d.level = found ? best_lvl : 8'h00;
        st_d.vec   = found && best_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req   = st_q.req;
    assign irq_id    = st_q.id;
    assign irq_level = st_q.level;
    assign irq_vec   = st_q.vec;
endmodule

// File: rtl/hart_intc.sv
`timescale 1ns/1ps
module hart_intc
    import hart_intc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int CTL_BITS = 4,
    parameter int VERSION  = 1,
    parameter int ADDR_W   = 12,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_id,
    output logic [7:0]         irq_level,
    output logic               irq_vec
);
    localparam logic [ADDR_W-1:0] REC_LO   = ADDR_W'(REC_BASE);
    localparam logic [ADDR_W-1:0] REC_HI   = ADDR_W'(REC_BASE + REC_BYTES * NUM_SRC);
    localparam logic [ADDR_W-1:0] CFG_A    = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] THR_A    = ADDR_W'(THR_ADDR);
    localparam logic [ADDR_W-3:0] INFO_W   = (ADDR_W-2)'(INFO_ADDR / 4);
    localparam logic [31:0]       INFO     = {7'd0, 4'(CTL_BITS), 8'(VERSION), 13'(NUM_SRC)};
    localparam logic [7:0]        LOW_ONES = 8'hFF >> CTL_BITS;

    typedef struct packed {
        logic [3:0] nl;
        logic [7:0] thr;
        logic [7:0] rdata;
    } glb_t;

    glb_t reg_q, reg_d;

    logic [NUM_SRC-1:0]               src_sync;
    logic [NUM_SRC-1:0]               src_pend, src_en, src_vec;
    logic [NUM_SRC-1:0][1:0]          src_trig;
    logic [NUM_SRC-1:0][CTL_BITS-1:0] src_ctl;
    logic [NUM_SRC-1:0][7:0]          ctl_byte;
    logic [NUM_SRC-1:0][3:0]          wr_strb;
    logic                             rec_hit, wr_rec;
    logic [ADDR_W-1:0]                rec_off;
    logic [IDX_W-1:0]                 rec_idx;
    logic [3:0]                       nl_eff;
    logic [7:0]                       rd_val;

    hart_intc_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_sync)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hart_intc_src #(.CTL_BITS(CTL_BITS)) u_src (
            .clk(clk), .rst_n(rst_n),
            .sync_in(src_sync[i]),
            .wr_strb(wr_strb[i]),
            .wdata(bus_wdata),
            .pend(src_pend[i]),
            .en(src_en[i]),
            .vec(src_vec[i]),
            .trig(src_trig[i]),
            .ctl_hi(src_ctl[i])
        );
        assign ctl_byte[i] = (8'(src_ctl[i]) << (8 - CTL_BITS)) | LOW_ONES;
    end

    assign nl_eff = (reg_q.nl > 4'(CTL_BITS)) ? 4'(CTL_BITS) : reg_q.nl;

    always_comb begin
        rec_hit = (bus_addr >= REC_LO) && (bus_addr < REC_HI);
        rec_off = bus_addr - REC_LO;
        rec_idx = rec_off[IDX_W+1:2];
        wr_rec  = bus_req && bus_we && rec_hit;

        for (int i = 0; i < NUM_SRC; i++) begin
            wr_strb[i] = (wr_rec && rec_idx == IDX_W'(i)) ? (4'b0001 << rec_off[1:0]) : 4'b0000;
        end

        rd_val = 8'h00;
        if (bus_addr == CFG_A) begin
            rd_val = {3'b000, reg_q.nl, 1'b0};
        end else if (bus_addr[ADDR_W-1:2] == INFO_W) begin
            rd_val = INFO[{bus_addr[1:0], 3'b000} +: 8];
        end else if (bus_addr == THR_A) begin
            rd_val = reg_q.thr;
        end else if (rec_hit) begin
            case (rec_off[1:0])
                2'd0:    rd_val = {7'd0, src_pend[rec_idx]};
                2'd1:    rd_val = {7'd0, src_en[rec_idx]};
                2'd2:    rd_val = {5'd0, src_trig[rec_idx], src_vec[rec_idx]};
                default: rd_val = ctl_byte[rec_idx];
            endcase
        end

        reg_d = reg_q;
        if (bus_req && bus_we) begin
            if (bus_addr == CFG_A) reg_d.nl  = bus_wdata[4:1];
            if (bus_addr == THR_A) reg_d.thr = bus_wdata;
        end
        if (bus_req && !bus_we) reg_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign bus_rdata = reg_q.rdata;

    hart_intc_arb #(.NUM_SRC(NUM_SRC), .CTL_BITS(CTL_BITS), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .pend(src_pend), .en(src_en), .vec(src_vec),
        .ctl_byte(ctl_byte), .nl_eff(nl_eff), .thr(reg_q.thr),
        .irq_req(irq_req), .irq_id(irq_id), .irq_level(irq_level), .irq_vec(irq_vec)
    );
endmodule

// File: rtl/hart_intc_chk.sv
`timescale 1ns/1ps
module hart_intc_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       pend,
    input logic [NUM_SRC-1:0]       en,
    input logic [NUM_SRC-1:0]       vec,
    input logic [NUM_SRC-1:0][1:0]  trig,
    input logic [NUM_SRC-1:0]       sync,
    input logic [NUM_SRC-1:0][3:0]  strb,
    input logic [7:0]               thr,
    input logic                     irq_req,
    input logic [IDX_W-1:0]         irq_id,
    input logic [7:0]               irq_level,
    input logic                     irq_vec
);
    logic [NUM_SRC-1:0] live_q, vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            vec_q  <= '0;
        end else begin
            live_q <= pend & en;
            vec_q  <= vec;
        end
    end

    assert_req_above_thr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level > $past(thr)));

    assert_no_candidate_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == '0) |-> !irq_req);

    assert_winner_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> live_q[irq_id]);

    assert_vec_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == vec_q[irq_id]));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(trig[i]) == 2'd1 || $past(trig[i]) == 2'd2) && $past(pend[i]) && !$past(strb[i][0]))
            |-> pend[i]);

        assert_level_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig[i]) == 2'd0 || $past(trig[i]) == 2'd3) |-> (pend[i] == $past(sync[i])));
    end
endmodule

bind hart_intc hart_intc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pend(src_pend), .en(src_en), .vec(src_vec), .trig(src_trig),
    .sync(src_sync), .strb(wr_strb), .thr(reg_q.thr),
    .irq_req(irq_req), .irq_id(irq_id), .irq_level(irq_level), .irq_vec(irq_vec)
);

// File: tb/hart_intc_bench.sv
`timescale 1ns/1ps
module hart_intc_bench;
    localparam int NUM_SRC = 8;
    localparam int ADDR_W  = 12;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_req = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [7:0]         bus_wdata = '0;
    logic [7:0]         bus_rdata;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               irq_req, irq_vec;
    logic [IDX_W-1:0]   irq_id;
    logic [7:0]         irq_level;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hart_intc u_hart_intc (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_req(irq_req), .irq_id(irq_id),
        .irq_level(irq_level), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] rec(input int i, input int k);
        return ADDR_W'('h100 + 4 * i + k);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R12 irq_req after reset", irq_req, 0);
        chk("R11 irq_id after reset", irq_id, 0);
        rd(12'h000, d); chk("R3 cfg reset", d, 'h00);
        rd(12'h008, d); chk("R5 thr reset", d, 'h00);
        rd(rec(0, 0), d); chk("R12 pend reset", d, 'h00);
        rd(rec(7, 2), d); chk("R12 attr reset", d, 'h00);
        rd(rec(3, 3), d); chk("R2 ctl reset reads 0x0F", d, 'h0F);
    endtask

    task automatic t_info();
        logic [7:0] d;
        rd(12'h004, d); chk("R4 info byte0", d, 'h08);
        rd(12'h005, d); chk("R4 info byte1", d, 'h20);
        rd(12'h006, d); chk("R4 info byte2", d, 'h80);
        rd(12'h007, d); chk("R4 info byte3", d, 'h00);
        wr(12'h004, 8'hFF);
        rd(12'h004, d); chk("R4 info write ignored", d, 'h08);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(rec(0, 3), 8'hA5);
        rd(rec(0, 3), d); chk("R2 ctl write 0xA5", d, 'hAF);
        wr(rec(0, 2), 8'hFF);
        rd(rec(0, 2), d); chk("R1 attr implemented bits", d, 'h07);
        wr(rec(0, 1), 8'hFF);
        rd(rec(0, 1), d); chk("R1 enable bit0 only", d, 'h01);
        wr(rec(0, 1), 8'h00);
        wr(rec(0, 2), 8'h00);
        wr(12'h000, 8'hFF);
        rd(12'h000, d); chk("R3 cfg field bits 4:1", d, 'h1E);
        wr(12'h000, 8'h04);
        rd(12'h000, d); chk("R3 cfg nlbits=2", d, 'h04);
        wr(12'h008, 8'h33);
        rd(12'h008, d); chk("R5 thr write", d, 'h33);
        wr(12'h008, 8'h00);
    endtask

    task automatic t_swpend();
        logic [7:0] d;
        wr(rec(2, 2), 8'h02);
        wr(rec(2, 3), 8'h40);
        wr(rec(2, 1), 8'h01);
        wr(rec(2, 0), 8'h01);
        settle();
        chk("R6 sw pend raises req", irq_req, 1);
        chk("R9 winner id", irq_id, 2);
        chk("R8 level nl=2 ctl=0x40", irq_level, 'h7F);
        chk("R11 non-vectored", irq_vec, 0);
        rd(rec(2, 0), d); chk("R6 pend reads 1", d, 1);
    endtask

    task automatic t_thr();
        wr(12'h008, 8'h7F); settle();
        chk("R10 level equal to thr no req", irq_req, 0);
        chk("R11 id held below thr", irq_id, 2);
        wr(12'h008, 8'h7E); settle();
        chk("R10 level above thr req", irq_req, 1);
        wr(12'h008, 8'h00);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        wr(rec(2, 1), 8'h00); settle();
        chk("R10 disabled source no req", irq_req, 0);
        chk("R11 no candidate level 0", irq_level, 0);
        wr(rec(2, 1), 8'h01); settle();
        chk("R9 re-enabled req", irq_req, 1);
        wr(rec(2, 0), 8'h00); settle();
        chk("R6 write 0 clears req", irq_req, 0);
        rd(rec(2, 0), d); chk("R6 pend cleared", d, 0);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        wr(rec(3, 2), 8'h02);
        wr(rec(3, 3), 8'h40);
        wr(rec(3, 1), 8'h01);
        src_in[3] = 1'b1; settle();
        rd(rec(3, 0), d); chk("R6 rising edge pends", d, 1);
        chk("R9 rising source wins", irq_id, 3);
        src_in[3] = 1'b0; settle();
        rd(rec(3, 0), d); chk("R6 edge pend sticky", d, 1);
        wr(rec(3, 0), 8'h00);
        rd(rec(3, 0), d); chk("R6 edge pend cleared", d, 0);
    endtask

    task automatic t_fall();
        logic [7:0] d;
        wr(rec(4, 2), 8'h04);
        wr(rec(4, 1), 8'h01);
        src_in[4] = 1'b1; settle();
        rd(rec(4, 0), d); chk("R6 falling mode ignores rise", d, 0);
        src_in[4] = 1'b0; settle();
        rd(rec(4, 0), d); chk("R6 falling edge pends", d, 1);
        wr(rec(4, 0), 8'h00);
        wr(rec(4, 1), 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(rec(5, 2), 8'h00);
        wr(rec(5, 1), 8'h01);
        src_in[5] = 1'b1; settle();
        rd(rec(5, 0), d); chk("R7 level pend follows high", d, 1);
        chk("R9 level source wins", irq_id, 5);
        wr(rec(5, 0), 8'h00);
        rd(rec(5, 0), d); chk("R7 write 0 ignored", d, 1);
        src_in[5] = 1'b0; settle();
        rd(rec(5, 0), d); chk("R7 level pend follows low", d, 0);
        wr(rec(5, 0), 8'h01);
        rd(rec(5, 0), d); chk("R7 write 1 ignored", d, 0);
        chk("R10 no req after level drop", irq_req, 0);
        wr(rec(5, 1), 8'h00);
    endtask

    task automatic t_arb();
        wr(rec(1, 2), 8'h02); wr(rec(1, 1), 8'h01);
        wr(rec(6, 2), 8'h02); wr(rec(6, 1), 8'h01);
        wr(rec(1, 3), 8'h80); wr(rec(6, 3), 8'h70);
        wr(rec(1, 0), 8'h01); wr(rec(6, 0), 8'h01);
        settle();
        chk("R9 higher level beats priority", irq_id, 1);
        chk("R8 level of 0x80 nl=2", irq_level, 'hBF);
        wr(rec(1, 3), 8'h40); wr(rec(6, 3), 8'h50); settle();
        chk("R9 priority breaks level tie", irq_id, 6);
        wr(rec(1, 3), 8'h60); settle();
        chk("R9 priority breaks tie low id", irq_id, 1);
        wr(rec(1, 3), 8'h50); settle();
        chk("R9 full tie higher id", irq_id, 6);
    endtask

    task automatic t_nl();
        wr(12'h000, 8'h00); settle();
        chk("R8 nlbits=0 level all ones", irq_level, 'hFF);
        wr(12'h000, 8'h02); settle();
        chk("R8 nlbits=1 level", irq_level, 'h7F);
        wr(12'h000, 8'h1E); settle();
        chk("R8 nlbits clamped to CTL_BITS", irq_level, 'h5F);
        wr(12'h000, 8'h04);
    endtask

    task automatic t_vec();
        wr(rec(6, 2), 8'h03); settle();
        chk("R11 vectored flag", irq_vec, 1);
        chk("R11 vectored id", irq_id, 6);
        wr(rec(1, 0), 8'h00); wr(rec(6, 0), 8'h00); settle();
        chk("R10 all cleared no req", irq_req, 0);
        chk("R11 cleared vec", irq_vec, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_info();
        t_regs();
        t_swpend();
        t_thr();
        t_disable();
        t_rise();
        t_fall();
        t_level();
        t_arb();
        t_nl();
        t_vec();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule